// File: doc/BRIEF.md
# Byte-Wide SPI Port with Sequence-Cleared Flags

This block is an 8-bit serial peripheral port for a small processor bus. Software sees three registers: a control register holding the interrupt enable and the master-select bit, a read-only status register with three event flags, and a data register. In master mode a write to the data register loads the byte straight into the shift register and sends it out on a clock made by a fixed divider of the system clock. The byte received at the same time is copied into a separate receive buffer when the transfer ends. In slave mode the block shifts on an external clock while its select input is low.

The flags are not cleared by writing ones to them. Each is cleared by an ordered pair of accesses. Software first reads the status register while the flag is set, which arms a clear for that flag. The next qualifying access then clears the flag: a data access for the completion and collision flags, or a control write for the mode-fault flag. An access made without the arming status read leaves the flag set. While the completion flag is set, data writes are dropped. A data write during a transfer raises the collision flag and does not disturb the byte being shifted. A low select input in master mode raises the mode-fault flag, drops the block out of master mode and stops the transfer.

Register addresses: 0 control, 1 status, 2 data. Control bit 0 enables the interrupt and control bit 1 selects master mode. Serial timing is mode 0: the clock idles low, data is sampled on the rising edge, bits go MSB first, and each half period of the master clock lasts `DIV_HALF` system clocks.

Top module: `spi_sq_top`

## Requirements
- R1: After reset the status register reads 00h, `irq` is 0 and `sclk_o` is low.
- R2: Status bit 7 is the completion flag, bit 6 the collision flag and bit 4 the mode-fault flag. Bits 5 and 3..0 always read 0. A read returns its value on `rdata` one clock after the read strobe.
- R3: In master mode, a data write accepted while the port is idle starts a transfer. The transfer gives exactly 8 rising edges on `sclk_o`, each phase `DIV_HALF` clocks long, and sends the byte on `mosi_o` MSB first, valid on each rising edge. `sclk_o` is low whenever no transfer is in progress.
- R4: When a transfer ends, the received byte is copied to the receive buffer and the completion flag sets. Data reads return that buffer, so a read during the next transfer returns the previous byte.
- R5: The completion flag clears only on a data read or write that follows a status read made while the flag was 1. A data access without that prior status read leaves the flag set.
- R6: A data write made while the completion flag is 1 is ignored. No transfer starts and the collision flag does not change.
- R7: A data write during an active transfer sets the collision flag. The byte in flight is still sent unchanged.
- R8: The collision flag is cleared by a status read made while it is set, followed by a data access.
- R9: When `ss_n_i` is low in master mode, the mode-fault flag sets, the master-select bit clears (a control read then shows it 0) and the running transfer stops without setting the completion flag.
- R10: The mode-fault flag clears only on a control write that follows a status read made while the flag was 1. A control write alone leaves it set.
- R11: `irq` is 1 exactly when the interrupt enable is 1 and the completion flag or the mode-fault flag is 1. It follows the flags with one register stage.
- R12: In slave mode with `ss_n_i` low, the block presents the loaded byte on `miso_o` MSB first and samples `mosi_i` on each rising edge of `sclk_i`. After 8 bits it stores the received byte in the buffer and sets the completion flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request |
| sclk_o | output | 1 | Serial clock driven in master mode |
| mosi_o | output | 1 | Serial data out in master mode |
| miso_i | input | 1 | Serial data in for master mode |
| sclk_i | input | 1 | Serial clock received in slave mode |
| mosi_i | input | 1 | Serial data in for slave mode |
| miso_o | output | 1 | Serial data out in slave mode |
| ss_n_i | input | 1 | Active-low select: chooses the slave, or signals a fault in master mode |

## Verification
The assertions assume that `rd_en` and `wr_en` are never high in the same cycle. They also assume that `ss_n_i`, `sclk_i` and `mosi_i` are already synchronous to `clk`, with every level held for several clocks. The bench drives only one strobe at a time, from the falling clock edge. It moves the slave-side pins four clocks apart and keeps `ss_n_i` high during master transfers, except in the one directed fault case. The random part draws the transmitted and returned bytes from a fixed seed and always runs the full status-then-data clear sequence between transfers, so each transfer starts from a cleared completion flag.

// File: rtl/spi_sq_pkg.sv
package spi_sq_pkg;
  typedef enum logic [1:0] {
    A_CTL  = 2'd0,
    A_STAT = 2'd1,
    A_DATA = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;

  localparam int CTL_IE   = 0;
  localparam int CTL_MST  = 1;
  localparam int ST_DONE  = 7;
  localparam int ST_COLL  = 6;
  localparam int ST_FAULT = 4;
endpackage

// File: rtl/spi_sq_shift.sv
module spi_sq_shift #(
  parameter int DW       = 8,
  parameter int DIV_HALF = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          master,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          abort,
  input  logic          miso_i,
  input  logic          sclk_s,
  input  logic          mosi_s,
  input  logic          ss_s,
  output logic          sclk_o,
  output logic          mosi_o,
  output logic          miso_o,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rx_buf
);
  localparam int CW  = (DW > 2) ? $clog2(DW) : 1;
  localparam int DCW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [DW-1:0]  sr;
  logic           smp;
  logic [CW-1:0]  bit_cnt;
  logic [DCW-1:0] div_cnt;
  logic           sclk_d;
  logic           tick, s_rise, s_fall, edge_r, edge_f, last;

  assign tick   = (div_cnt == DCW'(DIV_HALF - 1));
  assign s_rise = sclk_s & ~sclk_d & ~master & ~ss_s;
  assign s_fall = ~sclk_s & sclk_d & ~master & ~ss_s;
  assign edge_r = master ? (busy & tick & ~sclk_o) : s_rise;
  assign edge_f = master ? (busy & tick & sclk_o) : (s_fall & busy);
  assign last   = (bit_cnt == CW'(DW - 1));

  assign mosi_o = master & busy & sr[DW-1];
  assign miso_o = ~master & ~ss_s & sr[DW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sr      <= '0;
      smp     <= 1'b0;
      bit_cnt <= '0;
      div_cnt <= '0;
      sclk_d  <= 1'b0;
      sclk_o  <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      rx_buf  <= '0;
    end else begin
      sclk_d <= sclk_s;
      done   <= 1'b0;
      if (abort) begin
        busy    <= 1'b0;
        sclk_o  <= 1'b0;
        div_cnt <= '0;
        bit_cnt <= '0;
      end else if (load) begin
        sr      <= load_data;
        bit_cnt <= '0;
        div_cnt <= '0;
        sclk_o  <= 1'b0;
        busy    <= master;
      end else begin
        if (master && busy)
          div_cnt <= tick ? '0 : DCW'(div_cnt + 1'b1);
        if (!master && ss_s) begin
          busy    <= 1'b0;
          bit_cnt <= '0;
        end
        if (edge_r) begin
          smp <= master ? miso_i : mosi_s;
          if (master) sclk_o <= 1'b1;
          else        busy   <= 1'b1;
        end
        if (edge_f) begin
          sr      <= {sr[DW-2:0], smp};
          bit_cnt <= CW'(bit_cnt + 1'b1);
          if (master) sclk_o <= 1'b0;
          if (last) begin
            done    <= 1'b1;
            busy    <= 1'b0;
            bit_cnt <= '0;
            rx_buf  <= {sr[DW-2:0], smp};
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_sq_flags.sv
module spi_sq_flags (
  input  logic clk,
  input  logic rst,
  input  logic stat_rd,
  input  logic data_rd,
  input  logic data_wr,
  input  logic ctl_wr,
  input  logic done,
  input  logic busy,
  input  logic fault,
  output logic spif,
  output logic wcol,
  output logic modf,
  output logic wr_go
);
  logic data_acc, coll_set;
  logic arm_done, arm_coll, arm_fault;

  assign data_acc = data_rd | data_wr;
  assign wr_go    = data_wr & ~spif & ~busy;
  assign coll_set = data_wr & ~spif & busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      spif      <= 1'b0;
      wcol      <= 1'b0;
      modf      <= 1'b0;
      arm_done  <= 1'b0;
      arm_coll  <= 1'b0;
      arm_fault <= 1'b0;
    end else begin
      if (done)                      spif <= 1'b1;
      else if (arm_done && data_acc) spif <= 1'b0;
      if (stat_rd && spif)  arm_done <= 1'b1;
      else if (data_acc)    arm_done <= 1'b0;

      if (coll_set)                  wcol <= 1'b1;
      else if (arm_coll && data_acc) wcol <= 1'b0;
      if (stat_rd && wcol)  arm_coll <= 1'b1;
      else if (data_acc)    arm_coll <= 1'b0;

      if (fault)                    modf <= 1'b1;
      else if (arm_fault && ctl_wr) modf <= 1'b0;
      if (stat_rd && modf)  arm_fault <= 1'b1;
      else if (ctl_wr)      arm_fault <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_sq_top.sv
module spi_sq_top
  import spi_sq_pkg::*;
#(
  parameter int DW       = 8,
  parameter int DIV_HALF = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq,
  output logic          sclk_o,
  output logic          mosi_o,
  input  logic          miso_i,
  input  logic          sclk_i,
  input  logic          mosi_i,
  output logic          miso_o,
  input  logic          ss_n_i
);
  logic          stat_rd, data_rd, data_wr, ctl_wr;
  logic          ie_q, mst_q, ss_q, sclk_q, mosi_q;
  logic          fault, spif, wcol, modf, wr_go, busy, done;
  logic [DW-1:0] rx_buf, stat_v, ctl_v;

  assign stat_rd = rd_en && (addr == A_STAT);
  assign data_rd = rd_en && (addr == A_DATA);
  assign data_wr = wr_en && (addr == A_DATA);
  assign ctl_wr  = wr_en && (addr == A_CTL);
  assign fault   = mst_q & ~ss_q;

  always_comb begin
    stat_v           = '0;
    stat_v[ST_DONE]  = spif;
    stat_v[ST_COLL]  = wcol;
    stat_v[ST_FAULT] = modf;
    ctl_v            = '0;
    ctl_v[CTL_IE]    = ie_q;
    ctl_v[CTL_MST]   = mst_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q   <= 1'b0;
      mst_q  <= 1'b0;
      ss_q   <= 1'b1;
      sclk_q <= 1'b0;
      mosi_q <= 1'b0;
      rdata  <= '0;
      irq    <= 1'b0;
    end else begin
      ss_q   <= ss_n_i;
      sclk_q <= sclk_i;
      mosi_q <= mosi_i;
      irq    <= ie_q & (spif | modf);
      if (ctl_wr) begin
        ie_q  <= wdata[CTL_IE];
        mst_q <= wdata[CTL_MST];
      end
      if (fault) mst_q <= 1'b0;
      if (rd_en) begin
        case (addr)
          A_CTL:   rdata <= ctl_v;
          A_STAT:  rdata <= stat_v;
          A_DATA:  rdata <= rx_buf;
          default: rdata <= '0;
        endcase
      end
    end
  end

  spi_sq_flags u_flags (
    .clk(clk), .rst(rst), .stat_rd(stat_rd), .data_rd(data_rd),
    .data_wr(data_wr), .ctl_wr(ctl_wr), .done(done), .busy(busy),
    .fault(fault), .spif(spif), .wcol(wcol), .modf(modf), .wr_go(wr_go)
  );

  spi_sq_shift #(.DW(DW), .DIV_HALF(DIV_HALF)) u_shift (
    .clk(clk), .rst(rst), .master(mst_q), .load(wr_go), .load_data(wdata),
    .abort(fault), .miso_i(miso_i), .sclk_s(sclk_q), .mosi_s(mosi_q),
    .ss_s(ss_q), .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_o(miso_o),
    .busy(busy), .done(done), .rx_buf(rx_buf)
  );
endmodule

// File: rtl/spi_sq_chk.sv
module spi_sq_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          rd_en,
  input logic          wr_en,
  input logic [1:0]    addr,
  input logic [DW-1:0] rdata,
  input logic          irq,
  input logic          ie,
  input logic          mst,
  input logic          ss_q,
  input logic          spif,
  input logic          wcol,
  input logic          modf,
  input logic          busy,
  input logic          sclk_o
);
  a_r2_unused_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 2'd1) |=> (rdata[5] == 1'b0 && rdata[3:0] == 4'd0));

  a_r3_sclk_idle_low: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sclk_o);

  a_r5_done_held: assert property (@(posedge clk) disable iff (rst)
    (spif && !((rd_en || wr_en) && addr == 2'd2)) |=> spif);

  a_r6_write_blocked: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 2'd2 && spif && !busy && mst) |=> !busy);

  a_r7_collision: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 2'd2 && busy && !spif) |=> wcol);

  a_r9_fault_exit: assert property (@(posedge clk) disable iff (rst)
    (mst && !ss_q) |=> (!mst && modf));

  a_r10_fault_held: assert property (@(posedge clk) disable iff (rst)
    (modf && !(wr_en && addr == 2'd0)) |=> modf);

  a_r11_irq_off: assert property (@(posedge clk) disable iff (rst)
    !ie |=> !irq);
endmodule

bind spi_sq_top spi_sq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
  .rdata(rdata), .irq(irq), .ie(ie_q), .mst(mst_q), .ss_q(ss_q),
  .spif(spif), .wcol(wcol), .modf(modf), .busy(busy), .sclk_o(sclk_o)
);

// File: tb/spi_sq_top_tb.sv
module spi_sq_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_HALF   = 2;
  localparam int XFER_WAIT  = 8 * 2 * DIV_HALF + 6;

  logic       clk = 1'b0, rst = 1'b1;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0, rdata;
  logic       irq, sclk_o, mosi_o, miso_o;
  logic       miso_i = 1'b0, sclk_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;

  int errs = 0, checks = 0, pos = -1, rise_cnt = 0;
  logic [7:0] slv_tx = 8'd0, mosi_cap = 8'd0;
  bit finished = 1'b0;

  spi_sq_top #(.DW(8), .DIV_HALF(DIV_HALF)) u_dut (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .sclk_o(sclk_o),
    .mosi_o(mosi_o), .miso_i(miso_i), .sclk_i(sclk_i), .mosi_i(mosi_i),
    .miso_o(miso_o), .ss_n_i(ss_n_i)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // bench-side slave for master transfers
  always @(posedge sclk_o) begin
    mosi_cap = {mosi_cap[6:0], mosi_o};
    rise_cnt = rise_cnt + 1;
  end
  always @(negedge sclk_o) begin
    if (pos >= 0) begin
      miso_i = slv_tx[pos];
      pos    = pos - 1;
    end
  end

  function automatic logic [7:0] exp_stat(input bit d, input bit c, input bit f);
    return {d, c, 1'b0, f, 4'b0000};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic start_xfer(input logic [7:0] tx, input logic [7:0] rep);
    slv_tx = rep; miso_i = rep[7]; pos = 6; rise_cnt = 0; mosi_cap = 8'd0;
    wr(2'd2, tx);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v, prev, tx, rep, sbyte;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(2'd1, v);  check("R1 status", v, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 sclk", {7'd0, sclk_o}, 8'h00);

    wr(2'd0, 8'h03);
    rd(2'd0, v);  check("R9 ctl readback", v, 8'h03);

    // R3 R4 R5 basic master transfer
    start_xfer(8'hA5, 8'h3C);
    repeat (XFER_WAIT) @(negedge clk);
    check("R3 mosi bits", mosi_cap, 8'hA5);
    check("R3 edge count", 8'(rise_cnt), 8'd8);
    check("R11 irq on done", {7'd0, irq}, 8'h01);
    rd(2'd2, v);  check("R4 rx buffer", v, 8'h3C);
    rd(2'd1, v);  check("R5 no clear without status", v, exp_stat(1, 0, 0));
    rd(2'd2, v);  check("R4 rx reread", v, 8'h3C);
    rd(2'd1, v);  check("R5 cleared", v, exp_stat(0, 0, 0));
    check("R11 irq off", {7'd0, irq}, 8'h00);

    // R6 write while done pending
    start_xfer(8'h11, 8'hE4);
    repeat (XFER_WAIT) @(negedge clk);
    rise_cnt = 0;
    wr(2'd2, 8'h77);
    repeat (20) @(negedge clk);
    check("R6 no transfer", 8'(rise_cnt), 8'd0);
    rd(2'd1, v);  check("R6 status", v, exp_stat(1, 0, 0));
    rd(2'd2, v);  check("R6 buffer kept", v, 8'hE4);
    rd(2'd1, v);  check("R6 cleared", v, exp_stat(0, 0, 0));

    // R7 R8 collision
    start_xfer(8'h5A, 8'h81);
    repeat (6) @(negedge clk);
    wr(2'd2, 8'hFF);
    repeat (XFER_WAIT) @(negedge clk);
    check("R7 byte intact", mosi_cap, 8'h5A);
    rd(2'd1, v);  check("R7 status", v, exp_stat(1, 1, 0));
    rd(2'd2, v);  check("R7 rx", v, 8'h81);
    rd(2'd1, v);  check("R8 cleared", v, exp_stat(0, 0, 0));

    // R9 R10 mode fault
    start_xfer(8'h33, 8'h00);
    repeat (6) @(negedge clk);
    ss_n_i = 1'b0;
    repeat (3) @(negedge clk);
    ss_n_i = 1'b1;
    repeat (XFER_WAIT) @(negedge clk);
    check("R9 aborted", 8'(rise_cnt < 8), 8'd1);
    rd(2'd0, v);  check("R9 master dropped", v, 8'h01);
    wr(2'd0, 8'h01);
    rd(2'd1, v);  check("R10 held after bare write", v, exp_stat(0, 0, 1));
    check("R11 irq on fault", {7'd0, irq}, 8'h01);
    wr(2'd0, 8'h03);
    rd(2'd1, v);  check("R10 cleared", v, exp_stat(0, 0, 0));
    check("R11 irq off after fault", {7'd0, irq}, 8'h00);

    // R11 with interrupts disabled
    wr(2'd0, 8'h02);
    start_xfer(8'h6C, 8'h19);
    repeat (XFER_WAIT) @(negedge clk);
    check("R11 irq masked", {7'd0, irq}, 8'h00);
    rd(2'd1, v);  check("R11 status", v, exp_stat(1, 0, 0));
    rd(2'd2, v);  check("R4 rx", v, 8'h19);

    // R12 slave mode
    wr(2'd0, 8'h00);
    wr(2'd2, 8'hC3);
    ss_n_i = 1'b0;
    sbyte = 8'd0;
    repeat (4) @(negedge clk);
    for (int i = 7; i >= 0; i--) begin
      mosi_i = 1'(8'h96 >> i);
      repeat (4) @(negedge clk);
      sbyte = {sbyte[6:0], miso_o};
      sclk_i = 1'b1;
      repeat (4) @(negedge clk);
      sclk_i = 1'b0;
      repeat (4) @(negedge clk);
    end
    ss_n_i = 1'b1;
    repeat (4) @(negedge clk);
    check("R12 miso bits", sbyte, 8'hC3);
    rd(2'd1, v);  check("R12 status", v, exp_stat(1, 0, 0));
    rd(2'd2, v);  check("R12 rx", v, 8'h96);
    rd(2'd1, v);  check("R12 cleared", v, exp_stat(0, 0, 0));

    // random master transfers
    wr(2'd0, 8'h03);
    prev = 8'h96;
    for (int n = 0; n < 16; n++) begin
      tx  = 8'($urandom);
      rep = 8'($urandom);
      start_xfer(tx, rep);
      repeat (6) @(negedge clk);
      rd(2'd2, v);  check("R4 old buffer mid-transfer", v, prev);
      repeat (XFER_WAIT) @(negedge clk);
      check("R3 random mosi", mosi_cap, tx);
      check("R3 random edges", 8'(rise_cnt), 8'd8);
      rd(2'd1, v);  check("R2 random status", v, exp_stat(1, 0, 0));
      rd(2'd2, v);  check("R4 random rx", v, rep);
      rd(2'd1, v);  check("R5 random clear", v, exp_stat(0, 0, 0));
      prev = rep;
    end

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule